// File: doc/BRIEF.md
# Byte-Order Reordering Message Packer

This block sits between a write-only 32-bit data port and the byte-wide input of a hash core. Software programs a 64-bit message length in bits as two 32-bit halves, then writes a control word carrying a 2-bit byte-order code. That control write arms a new message. From then on, full 32-bit words arrive from a processor or from a DMA engine in short bursts. Each accepted word has its byte lanes permuted according to the byte-order code and is sent out one byte per cycle on a valid/ready stream.

The port carries no byte-valid mask, so the programmed length is the only source for how many bytes are real. The block loads the byte count, which is the bit length shifted right by three. Every word except the last adds four bytes. The final word adds only the bytes still owed, and its padding lanes are dropped. The final byte carries a last flag. A word written after the count is used up is taken off the port, dropped and flagged as an overflow. While a word is being emitted, the port stalls the writer.

The control is a five-state machine. IDLE waits for the first control write. GUARD holds the port closed after a control write. TAKE has the port open for the next word. EMIT streams the bytes of the captured word. DONE means the message is complete and any further word overflows. The transitions are:
- any state goes to GUARD on a control write;
- GUARD goes to TAKE when the guard time has elapsed;
- TAKE goes to EMIT on a word while bytes are still owed;
- TAKE goes to DONE on a word when no bytes are owed;
- EMIT goes back to TAKE after the last byte of a non-final word;
- EMIT goes to DONE after the last byte of the final word;
- DONE stays in DONE.

Top module: `msg_byte_packer`

## Requirements
- R1: The emit order of the four lanes of a word (lane k = bits 8k+7:8k) depends on the byte-order code. Code 0 emits lanes 0,1,2,3. Code 1 emits lanes 3,2,1,0. Code 2 emits lanes 0,1,3,2. Code 3 emits lanes 2,3,0,1.
- R2: Every word that is not the final word of the message produces exactly four output bytes.
- R3: The final word produces exactly the bytes still owed, from 1 to 4. Its remaining lanes never appear on the output.
- R4: The byte count is the 64-bit value {high half, low half} shifted right by 3. The lowest three bits of the bit length have no effect. The high half counts in full.
- R5: out_last is 1 on the final message byte only, and the stream stops after it.
- R6: After a control write sampled at clock edge t, wr_ready is 0 in the following cycle. The first word is accepted no earlier than edge t+2.
- R7: A word offered once the byte count is exhausted is taken, with wr_ready high. A zero-length message counts as exhausted. Such a word produces no output and sets ovf_err. ovf_err stays set until the next control write clears it.
- R8: While a word is being emitted, wr_ready is 0. While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R9: After reset, wr_ready, out_valid and ovf_err are 0 until a control write arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_hi_we | input | 1 | Write strobe for the upper half of the bit length |
| len_lo_we | input | 1 | Write strobe for the lower half of the bit length |
| len_wdata | input | 32 | Data for either length half |
| ctl_we | input | 1 | Control write; arms a new message |
| ctl_order | input | 2 | Byte-order code captured by the control write |
| wr_valid | input | 1 | Data word offered on the write port |
| wr_data | input | 32 | Data word |
| wr_ready | output | 1 | Write port accepts a word this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the final message byte |
| out_ready | input | 1 | Hash core takes the byte |
| ovf_err | output | 1 | Sticky flag: a word arrived past the message end |

## Verification
The bench sweeps all four byte-order codes against message lengths of 0 to 9 bytes. This covers every final-word fill, the zero-length case, and garbage in the three sub-byte bits of the length. A wrong lane table would scramble bytes within a word. A truncation error would leak padding bytes or drop real ones, and would misplace out_last. A length that ignored the high half is caught by a message whose count lives only in that half, since it would end at once. An extra word after each message must raise the overflow flag without producing output. The port must also stay closed in the cycle after arming and while bytes are stalled. Stalls are inserted on the output, so a design that let its byte change under back-pressure is also caught.

// File: rtl/msg_pack_pkg.sv
package msg_pack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GUARD,
        ST_TAKE,
        ST_EMIT,
        ST_DONE
    } pk_state_e;

    // Source lane for an output position; position 0 is emitted first.
    // The code's digit list names the source lanes of positions 3..0.
    function automatic logic [1:0] src_lane(input logic [1:0] code, input logic [1:0] pos);
        logic [7:0] digits;
        unique case (code)
            2'd0:    digits = 8'b11_10_01_00;
            2'd1:    digits = 8'b00_01_10_11;
            2'd2:    digits = 8'b10_11_01_00;
            default: digits = 8'b01_00_11_10;
        endcase
        return digits[2*pos +: 2];
    endfunction

endpackage

// File: rtl/msg_lane_reorder.sv
module msg_lane_reorder
    import msg_pack_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4
) (
    input  logic [1:0]              code,
    input  logic [BYTE_W*LANES-1:0] din,
    output logic [BYTE_W*LANES-1:0] dout
);
    for (genvar p = 0; p < LANES; p++) begin : g_pos
        logic [1:0] lane;
        assign lane = src_lane(code, 2'(p));
        assign dout[p*BYTE_W +: BYTE_W] = din[int'(lane)*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/msg_len_tracker.sv
module msg_len_tracker #(
    parameter int LEN_W  = 64,
    parameter int HALF_W = 32,
    parameter int LANES  = 4,
    localparam int CNT_W = LEN_W - 3,
    localparam int NB_W  = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [HALF_W-1:0] wdata,
    input  logic              load,
    input  logic              take,
    output logic [NB_W-1:0]   take_n,
    output logic              is_final,
    output logic              empty
);
    logic [HALF_W-1:0] hi_q, lo_q;
    logic [CNT_W-1:0]  left_q;
    logic [LEN_W-1:0]  bits_full;

    assign bits_full = {hi_q, lo_q};
    assign take_n    = (left_q >= CNT_W'(LANES)) ? NB_W'(LANES) : left_q[NB_W-1:0];
    assign is_final  = (left_q <= CNT_W'(LANES));
    assign empty     = (left_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            left_q <= '0;
        end else begin
            if (hi_we) hi_q <= wdata;
            if (lo_we) lo_q <= wdata;
            if (load)
                left_q <= CNT_W'(bits_full >> 3);
            else if (take)
                left_q <= left_q - CNT_W'(take_n);
        end
    end
endmodule

// File: rtl/msg_byte_packer.sv
module msg_byte_packer
    import msg_pack_pkg::*;
#(
    parameter int GUARD_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        len_hi_we,
    input  logic        len_lo_we,
    input  logic [31:0] len_wdata,
    input  logic        ctl_we,
    input  logic [1:0]  ctl_order,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    output logic        wr_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    input  logic        out_ready,
    output logic        ovf_err
);
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int NB_W   = $clog2(LANES + 1);
    localparam int GW     = (GUARD_CYC > 2) ? $clog2(GUARD_CYC) : 1;

    pk_state_e         state_q, state_d;
    logic [GW-1:0]     guard_q;
    logic [1:0]        order_q;
    logic [WORD_W-1:0] word_q, word_perm;
    logic [NB_W-1:0]   nbytes_q, idx_q, take_n;
    logic              final_q, err_q;
    logic              is_final, empty, take, accept, drop, end_word;

    msg_lane_reorder #(.BYTE_W(BYTE_W), .LANES(LANES)) u_reorder (
        .code (order_q),
        .din  (wr_data),
        .dout (word_perm)
    );

    msg_len_tracker #(.LEN_W(64), .HALF_W(32), .LANES(LANES)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_we    (len_hi_we),
        .lo_we    (len_lo_we),
        .wdata    (len_wdata),
        .load     (ctl_we),
        .take     (take),
        .take_n   (take_n),
        .is_final (is_final),
        .empty    (empty)
    );

    assign end_word = (idx_q == nbytes_q - NB_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        wr_ready  = 1'b0;
        out_valid = 1'b0;
        take      = 1'b0;
        accept    = 1'b0;
        drop      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_GUARD: begin
                if (guard_q == '0) state_d = ST_TAKE;
            end
            ST_TAKE: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    if (empty) begin
                        drop    = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        accept  = 1'b1;
                        take    = 1'b1;
                        state_d = ST_EMIT;
                    end
                end
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                if (out_ready && end_word) state_d = final_q ? ST_DONE : ST_TAKE;
            end
            ST_DONE: begin
                wr_ready = 1'b1;
                drop     = wr_valid;
            end
            default: state_d = ST_IDLE;
        endcase
        if (ctl_we) state_d = ST_GUARD;
    end

    assign out_data = word_q[int'(idx_q)*BYTE_W +: BYTE_W];
    assign out_last = out_valid && final_q && end_word;
    assign ovf_err  = err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            guard_q  <= '0;
            order_q  <= '0;
            word_q   <= '0;
            nbytes_q <= '0;
            idx_q    <= '0;
            final_q  <= 1'b0;
            err_q    <= 1'b0;
        end else if (ctl_we) begin
            order_q <= ctl_order;
            guard_q <= GW'(GUARD_CYC - 2);
            err_q   <= 1'b0;
        end else begin
            if (state_q == ST_GUARD && guard_q != '0) guard_q <= guard_q - GW'(1);
            if (drop) err_q <= 1'b1;
            if (accept) begin
                word_q   <= word_perm;
                nbytes_q <= take_n;
                final_q  <= is_final;
                idx_q    <= '0;
            end else if (state_q == ST_EMIT && out_ready) begin
                idx_q <= idx_q + NB_W'(1);
            end
        end
    end
endmodule

// File: rtl/msg_byte_packer_chk.sv
module msg_byte_packer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       out_ready,
    input logic       ovf_err
);
    // R6: port closed in the cycle after arming
    a_r6_guard_closed: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_we) |-> !wr_ready);

    // R8: no word accepted while a byte is pending
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !wr_ready);

    // R8: stalled byte holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !ctl_we) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

    // R7: overflow only rises after a word was taken
    a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_err) |-> $past(wr_valid && wr_ready));

    // R7: arming clears the overflow flag
    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_we) |-> !ovf_err);

    // R5: stream stops after the final byte
    a_r5_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last && out_ready && !ctl_we) |=> !out_valid);
endmodule

bind msg_byte_packer msg_byte_packer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready),
    .ovf_err   (ovf_err)
);

// File: tb/tb_msg_byte_packer.sv
module tb_msg_byte_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        len_hi_we = 1'b0, len_lo_we = 1'b0;
    logic [31:0] len_wdata = '0;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_order = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        out_ready = 1'b0;
    logic        ovf_err;

    int n_tests = 0;
    int n_fail  = 0;
    int msg_id  = 0;

    always #10 clk = ~clk;

    msg_byte_packer dut (
        .clk(clk), .rst_n(rst_n), .len_hi_we(len_hi_we), .len_lo_we(len_lo_we),
        .len_wdata(len_wdata), .ctl_we(ctl_we), .ctl_order(ctl_order),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .ovf_err(ovf_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_lane(input int code, input int j);
        case (code)
            0: return j;
            1: return 3 - j;
            2: return (j < 2) ? j : 5 - j;
            default: return (j + 2) % 4;
        endcase
    endfunction

    function automatic logic [7:0] lane_val(input int m, input int w, input int lane);
        return 8'((m << 4) + (w << 2) + lane);
    endfunction

    task automatic write_len(input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk); len_hi_we = 1'b1; len_wdata = hi;
        @(negedge clk); len_hi_we = 1'b0; len_lo_we = 1'b1; len_wdata = lo;
        @(negedge clk); len_lo_we = 1'b0;
    endtask

    task automatic arm(input int code);
        ctl_we = 1'b1; ctl_order = 2'(code);
        @(negedge clk); ctl_we = 1'b0;
        chk(wr_ready == 1'b0, "R6 closed after arm", longint'(wr_ready), 0);
        @(negedge clk);
        chk(wr_ready == 1'b1, "R6 open two cycles after arm", longint'(wr_ready), 1);
    endtask

    task automatic send_word(input logic [31:0] d);
        wr_valid = 1'b1; wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic get_byte(input bit stall, output logic [7:0] d, output logic l);
        logic [7:0] hold;
        while (!out_valid) @(negedge clk);
        chk(wr_ready == 1'b0, "R8 port stalled while emitting", longint'(wr_ready), 0);
        if (stall) begin
            out_ready = 1'b0; hold = out_data;
            @(negedge clk);
            chk(out_valid && out_data == hold, "R8 byte held under stall",
                longint'(out_data), longint'(hold));
        end
        out_ready = 1'b1; d = out_data; l = out_last;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    function automatic logic [31:0] mk_word(input int m, input int w);
        return {lane_val(m, w, 3), lane_val(m, w, 2), lane_val(m, w, 1), lane_val(m, w, 0)};
    endfunction

    task automatic run_msg(input int code, input int nb, input int junk);
        int nwords;
        logic [7:0] d;
        logic l;
        write_len(32'h0, 32'(nb * 8 + junk));
        arm(code);
        nwords = (nb + 3) / 4;
        for (int w = 0; w < nwords; w++) begin
            int cnt;
            cnt = (w == nwords - 1) ? nb - 4 * w : 4;
            send_word(mk_word(msg_id, w));
            for (int j = 0; j < cnt; j++) begin
                get_byte(((j + w + msg_id) % 3) == 0, d, l);
                chk(d == lane_val(msg_id, w, exp_lane(code, j)), "R1/R4 byte order and count",
                    longint'(d), longint'(lane_val(msg_id, w, exp_lane(code, j))));
                chk(l == ((w == nwords - 1) && (j == cnt - 1)), "R5 last flag placement",
                    longint'(l), longint'((w == nwords - 1) && (j == cnt - 1)));
            end
            chk(!out_valid, w == nwords - 1 ? "R3 final word truncated" : "R2 four bytes per word",
                longint'(out_valid), 0);
        end
        chk(ovf_err == 1'b0, "R7 no overflow within message", longint'(ovf_err), 0);
        send_word(32'hDEAD_BEEF);
        chk(ovf_err == 1'b1, "R7 extra word flags overflow", longint'(ovf_err), 1);
        chk(!out_valid, "R7 extra word dropped", longint'(out_valid), 0);
        msg_id++;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic l;
        repeat (3) @(negedge clk);
        chk(!wr_ready && !out_valid && !ovf_err, "R9 reset state",
            longint'({wr_ready, out_valid, ovf_err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!wr_ready && !out_valid && !ovf_err, "R9 idle after reset",
            longint'({wr_ready, out_valid, ovf_err}), 0);

        for (int code = 0; code < 4; code++)
            for (int nb = 0; nb < 10; nb++)
                run_msg(code, nb, (nb + code) % 8);

        // R4: a count held only in the high half must not end early
        write_len(32'h1, 32'h0);
        arm(2);
        for (int w = 0; w < 3; w++) begin
            send_word(mk_word(msg_id, w));
            for (int j = 0; j < 4; j++) begin
                get_byte(1'b0, d, l);
                chk(d == lane_val(msg_id, w, exp_lane(2, j)), "R4 high half byte",
                    longint'(d), longint'(lane_val(msg_id, w, exp_lane(2, j))));
                chk(l == 1'b0, "R4 high half no early last", longint'(l), 0);
            end
        end
        chk(ovf_err == 1'b0 && wr_ready, "R4 high half still accepting",
            longint'({ovf_err, wr_ready}), 1);
        msg_id++;
        // R7: re-arming mid-message starts clean
        run_msg(1, 5, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule